// File: doc/BRIEF.md
# Triple-Redundant Self-Checking Adder with Voted Error Flag

This block wraps three identical copies of a self-checking ripple-carry adder and resolves their results by bitwise two-out-of-three voting. Each copy carries, beside its normal sum and carry logic, a separate predictor that computes the expected parity of every bit's (sum, carry-out) pair straight from that bit's three inputs. The copy's error flag is raised when any bit's outputs disagree with its prediction.

The voted sum and the voted carry hide a single faulty copy, as in plain triple redundancy. The three error flags are voted as well. When two or more copies are hit, a data vote may settle on a wrong value. In that case the voted error flag is raised, so the failure is detected rather than passed downstream. The block also reports each copy's own error flag, a per-copy disagreement vector, and a flag that marks a single fault which the vote masked.

The block is purely combinational and has no clock and no reset. Each copy has fault-injection inputs on its sum bits, its carry-outs and its parity predictions, so that single-copy and multi-copy fault cases can be created on purpose.

Top module: `fdtmr_adder`

## Requirements
- R1: With no fault injected, each copy produces {carry-out, sum} = a + b + cin over W bits.
- R2: Each copy's error flag is the OR, over all bits, of sum_i XOR carryout_i XOR pred_i. Here pred_i is 1 exactly when that bit's a, b and carry-in are not all equal. A fault-free copy reports 0, and a copy with one flipped sum, carry or prediction bit reports 1.
- R3: `sum_o` and `cout_o` are the bitwise two-out-of-three majority of the three copies. A fault confined to one copy therefore never changes them.
- R4: `err_o` is the two-out-of-three majority of the three copies' error flags.
- R5: When two copies have flagged faults, `err_o` is 1, including the case where both copies carry the same wrong data and the data vote is wrong.
- R6: `rep_err_o[k]` is copy k's own error flag.
- R7: `rep_dis_o[k]` is 1 when copy k's {carry-out, sum} differs from {`cout_o`, `sum_o`}.
- R8: `mask_only_o` is 1 exactly when one copy, and only one, has its error flag or its disagreement bit set, and `err_o` is 0.
- R9: Copy k uses slice [k*W +: W] of each injection input. A set `inj_sum_i` bit flips that sum output. A set `inj_cout_i` bit flips that bit's carry-out, both into the next bit (or `cout` at bit W-1) and into its own check. A set `inj_par_i` bit flips that bit's prediction and leaves the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First addend |
| b_i | input | W | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| inj_sum_i | input | 3*W | Per-copy sum-bit fault flips |
| inj_cout_i | input | 3*W | Per-copy carry-out fault flips |
| inj_par_i | input | 3*W | Per-copy parity-prediction fault flips |
| sum_o | output | W | Voted sum |
| cout_o | output | 1 | Voted carry-out |
| err_o | output | 1 | Voted error flag |
| rep_err_o | output | 3 | Error flag of each copy |
| rep_dis_o | output | 3 | Copy disagrees with the voted data |
| mask_only_o | output | 1 | A single fault was masked |

## Verification
All state in this block is combinational. A wrong internal value, such as a bad carry, a bad prediction or a miswired voter input, appears at the outputs in the same cycle as the input vector that exposes it. It shows up as a wrong voted sum, a missing or spurious copy error bit, or a wrong mask flag. A four-bit configuration is swept over every addend and carry-in combination. Each combination is applied under eight fault patterns: none, each of the three fault kinds alone in one copy, two copies hit alike or differently, all three copies hit, and a sum flip cancelled by a prediction flip. The expected copy results come from bit-level arithmetic in the bench.

// File: rtl/fdtmr_pkg.sv
package fdtmr_pkg;
    localparam int NREP = 3;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction
endpackage

// File: rtl/fd_bit_cell.sv
module fd_bit_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic ci_i,
    input  logic f_sum_i,
    input  logic f_co_i,
    input  logic f_par_i,
    output logic s_o,
    output logic co_o,
    output logic chk_o
);
    logic s_raw, co_raw, pred;

    always_comb begin
        s_raw  = a_i ^ b_i ^ ci_i;
        co_raw = (a_i & b_i) | (ci_i & (a_i ^ b_i));
        // prediction built from inputs only, never from s_raw/co_raw
        pred   = (a_i | b_i | ci_i) & ~(a_i & b_i & ci_i);
        s_o    = s_raw ^ f_sum_i;
        co_o   = co_raw ^ f_co_i;
        chk_o  = s_o ^ co_o ^ (pred ^ f_par_i);
    end

    always_comb begin
        if (!f_sum_i && !f_co_i && !f_par_i)
            p_clean_cell_r2: assert (chk_o == 1'b0);
    end
endmodule

// File: rtl/fd_adder_chain.sv
module fd_adder_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [W-1:0] f_sum_i,
    input  logic [W-1:0] f_co_i,
    input  logic [W-1:0] f_par_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         err_o
);
    logic [W:0]   carry;
    logic [W-1:0] chk;

    assign carry[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        fd_bit_cell u_cell (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .ci_i    (carry[i]),
            .f_sum_i (f_sum_i[i]),
            .f_co_i  (f_co_i[i]),
            .f_par_i (f_par_i[i]),
            .s_o     (sum_o[i]),
            .co_o    (carry[i+1]),
            .chk_o   (chk[i])
        );
    end

    assign cout_o = carry[W];
    assign err_o  = |chk;

    always_comb begin
        if (f_sum_i == '0 && f_co_i == '0 && f_par_i == '0)
            p_add_ok_r1: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)));
    end
endmodule

// File: rtl/tmr_vote.sv
module tmr_vote #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] v_o
);
    import fdtmr_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_maj
        assign v_o[i] = maj3(x_i[i], y_i[i], z_i[i]);
    end

    always_comb begin
        p_two_agree_r3: assert (((x_i ~^ y_i) & (v_o ^ x_i)) == '0);
        p_two_agree_b_r3: assert (((y_i ~^ z_i) & (v_o ^ z_i)) == '0);
    end
endmodule

// File: rtl/fdtmr_adder.sv
module fdtmr_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           cin_i,
    input  logic [3*W-1:0] inj_sum_i,
    input  logic [3*W-1:0] inj_cout_i,
    input  logic [3*W-1:0] inj_par_i,
    output logic [W-1:0]   sum_o,
    output logic           cout_o,
    output logic           err_o,
    output logic [2:0]     rep_err_o,
    output logic [2:0]     rep_dis_o,
    output logic           mask_only_o
);
    import fdtmr_pkg::*;

    localparam int CW = $clog2(NREP + 1);

    logic [W-1:0] rep_sum [NREP];
    logic         rep_co  [NREP];
    logic         rep_er  [NREP];
    logic [NREP-1:0] suspect;
    logic [CW-1:0]   n_susp;

    for (genvar k = 0; k < NREP; k++) begin : g_rep
        fd_adder_chain #(.W(W)) u_chain (
            .a_i     (a_i),
            .b_i     (b_i),
            .cin_i   (cin_i),
            .f_sum_i (inj_sum_i[k*W +: W]),
            .f_co_i  (inj_cout_i[k*W +: W]),
            .f_par_i (inj_par_i[k*W +: W]),
            .sum_o   (rep_sum[k]),
            .cout_o  (rep_co[k]),
            .err_o   (rep_er[k])
        );
        assign rep_err_o[k] = rep_er[k];
        assign rep_dis_o[k] = {rep_co[k], rep_sum[k]} != {cout_o, sum_o};
    end

    tmr_vote #(.W(W)) u_vote_sum (
        .x_i (rep_sum[0]), .y_i (rep_sum[1]), .z_i (rep_sum[2]), .v_o (sum_o)
    );
    tmr_vote #(.W(1)) u_vote_co (
        .x_i (rep_co[0]), .y_i (rep_co[1]), .z_i (rep_co[2]), .v_o (cout_o)
    );
    tmr_vote #(.W(1)) u_vote_err (
        .x_i (rep_er[0]), .y_i (rep_er[1]), .z_i (rep_er[2]), .v_o (err_o)
    );

    always_comb begin
        suspect = rep_err_o | rep_dis_o;
        n_susp  = '0;
        for (int k = 0; k < NREP; k++)
            n_susp = n_susp + CW'(suspect[k]);
        mask_only_o = (n_susp == CW'(1)) && !err_o;
    end

    always_comb begin
        if ($countones(rep_err_o) >= 2)
            p_multi_err_r5: assert (err_o);
        if (mask_only_o)
            p_mask_excl_r8: assert (!err_o && $onehot0(rep_err_o));
        if (rep_err_o == 3'b000 && rep_dis_o == 3'b000)
            p_quiet_r8: assert (!mask_only_o && !err_o);
        p_err_vote_r4: assert (err_o == ($countones(rep_err_o) >= 2));
    end
endmodule

// File: tb/fdtmr_adder_tb.sv
`timescale 1ns/1ps
module fdtmr_adder_tb_top;
    localparam int W = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0]   a, b;
    logic           cin;
    logic [3*W-1:0] isum, icout, ipar;
    logic [W-1:0]   sum;
    logic           cout, err, mask_only;
    logic [2:0]     rep_err, rep_dis;

    int nvec = 0, nchk = 0, nfail = 0;
    bit done = 0;

    fdtmr_adder #(.W(W)) dut_i (
        .a_i(a), .b_i(b), .cin_i(cin),
        .inj_sum_i(isum), .inj_cout_i(icout), .inj_par_i(ipar),
        .sum_o(sum), .cout_o(cout), .err_o(err),
        .rep_err_o(rep_err), .rep_dis_o(rep_dis), .mask_only_o(mask_only)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h (a=%0h b=%0h cin=%0b)", tag, act, exp, a, b, cin);
        end
    endtask

    // bit-level arithmetic model of one copy under injected flips (R9)
    task automatic model(input logic [W-1:0] sm, cm, pm,
                         output logic [W-1:0] s, output logic co, output logic e);
        logic c;
        logic [1:0] t;
        c = cin;
        for (int i = 0; i < W; i++) begin
            t = 2'(a[i]) + 2'(b[i]) + 2'(c);
            s[i] = t[0] ^ sm[i];
            c = t[1] ^ cm[i];
        end
        co = c;
        e = |(sm ^ cm ^ pm);
    endtask

    task automatic run_vec(input int sc);
        logic [W-1:0] rs [3];
        logic rc [3];
        logic re [3];
        logic [W-1:0] vs, one;
        logic vc, ve, ms;
        logic [2:0] xe, xd, susp;
        logic [W:0] ref_sum;
        int j;
        j = (int'(a) + sc) % W;
        one = W'(1) << j;
        isum = '0; icout = '0; ipar = '0;
        case (sc)
            1: isum[0*W +: W] = one;                        // one copy, sum flip
            2: icout[1*W +: W] = one;                       // one copy, carry flip
            3: ipar[2*W +: W] = one;                        // one copy, prediction flip
            4: begin isum[0*W +: W] = one; isum[1*W +: W] = one; end // same wrong data twice
            5: begin isum[1*W +: W] = one; icout[2*W +: W] = one; end
            6: ipar = {3{one}};                             // all copies flagged
            7: begin isum[0*W +: W] = one; ipar[0*W +: W] = one; end // check cancels
            default: ;
        endcase
        for (int k = 0; k < 3; k++)
            model(isum[k*W +: W], icout[k*W +: W], ipar[k*W +: W], rs[k], rc[k], re[k]);
        vs = (rs[0] & rs[1]) | (rs[1] & rs[2]) | (rs[0] & rs[2]);
        vc = (rc[0] & rc[1]) | (rc[1] & rc[2]) | (rc[0] & rc[2]);
        ve = (re[0] & re[1]) | (re[1] & re[2]) | (re[0] & re[2]);
        for (int k = 0; k < 3; k++) begin
            xe[k] = re[k];
            xd[k] = {rc[k], rs[k]} != {vc, vs};
        end
        susp = xe | xd;
        ms = ($countones(susp) == 1) && !ve;
        ref_sum = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
        #2;
        nvec++;
        chk("R3 voted sum", 16'(sum), 16'(vs));
        chk("R3 voted cout", 16'(cout), 16'(vc));
        chk("R4 voted err", 16'(err), 16'(ve));
        chk("R6 R2 copy err vector", 16'(rep_err), 16'(xe));
        chk("R7 disagreement vector", 16'(rep_dis), 16'(xd));
        chk("R8 mask_only", 16'(mask_only), 16'(ms));
        if (sc == 0) begin
            chk("R1 fault-free add", 16'({cout, sum}), 16'(ref_sum));
            chk("R2 fault-free copies quiet", 16'(rep_err), 16'd0);
        end
        if (sc >= 1 && sc <= 3) begin
            chk("R3 R9 single fault masked", 16'({cout, sum}), 16'(ref_sum));
            chk("R8 single fault reported masked", 16'(mask_only), 16'd1);
        end
        if (sc == 3)
            chk("R9 prediction flip leaves data", 16'(rep_dis), 16'd0);
        if (sc == 4) begin
            chk("R5 wrong vote detected", 16'(err), 16'd1);
            chk("R5 wrong vote data", 16'({cout, sum}), 16'(ref_sum ^ (W+1)'(one)));
        end
        if (sc == 7)
            chk("R2 R9 cancelled check", 16'(rep_err), 16'd0);
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0; isum = '0; icout = '0; ipar = '0;
        @(posedge clk); #1;
        nvec++;
        chk("R1 idle sum", 16'({cout, sum}), 16'd0);
        chk("R8 idle flags", 16'({err, rep_err, rep_dis, mask_only}), 16'd0);
        for (int ia = 0; ia < (1 << W); ia++)
            for (int ib = 0; ib < (1 << W); ib++)
                for (int ic = 0; ic < 2; ic++)
                    for (int sc = 0; sc < 8; sc++) begin
                        @(posedge clk); #1;
                        a = W'(ia); b = W'(ib); cin = ic[0];
                        run_vec(sc);
                    end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule